// File: doc/BRIEF.md
# Microwire serial EEPROM command controller

This block lets a host processor run single-word operations on a three-wire Microwire serial EEPROM organised as 64 words of 16 bits. The host places data to be written in a write-data register, then writes a command (an operation code and a 6-bit word address). The command sets a busy flag. The block then drives chip select, serial clock and the data line to the device. When the operation ends it clears busy, and after a read the fetched word waits in a read-data register.

Writes and erases are self-timed inside the EEPROM. After the frame, the controller briefly drops chip select, raises it again, and keeps clocking the device while it watches the data line for the ready level. A device that never reports ready is caught by a cycle counter, set by default to 30 ms at 100 MHz. When that counter runs out, the command is abandoned, busy falls and a sticky timeout flag rises. When the interface-enable input is low, the clock and data pins follow two general-purpose values and no command is accepted.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, busy, timeout, chip select, serial clock and rdata are all 0.
- R2: A cmd_wr pulse with if_en high and busy low is accepted, and busy reads 1 on the next cycle. Busy stays 1 until the operation ends. cmd_op codes: 0 read, 1 write, 2 erase, 3 write-enable, 4 write-disable, 5 erase-all, 6 write-all (7 acts as write-disable).
- R3: A cmd_wr pulse while busy is 1 is ignored: no second frame is sent and the running operation is not changed.
- R4: A frame raises chip select and then sends, MSB first, a start bit 1, a 2-bit opcode (read 10, write 01, erase 11, extended 00) and the 6-bit address. The data line changes only while the serial clock is low and is held across each rising edge.
- R5: A write sends the 16-bit word last loaded through wdata_wr, MSB first, right after the address bits.
- R6: A read ignores the dummy bit that follows the address. It then samples 16 bits MSB first on rising clock edges, and the word appears on rdata in the same cycle busy falls.
- R7: After a write, erase, erase-all or write-all frame, chip select stays low for one half clock period and then rises. Busy ends only once the data line is sampled high at a rising-edge slot.
- R8: If an operation has not ended TO_CYCLES cycles after acceptance, it is aborted: chip select drops, busy falls and timeout rises. Timeout stays 1 with no further command.
- R9: An accepted command clears timeout in the same cycle that busy rises.
- R10: With if_en low, mw_sk and mw_do follow gpo_sclk and gpo_data, chip select is 0, and cmd_wr starts nothing.
- R11: The serial clock has a period of 2*CLK_DIV system cycles while chip select is high, and is 0 whenever chip select is low.
- R12: Extended commands carry their code in address bits 5:4: write-enable 11, write-disable 00, erase-all 10, write-all 01. Together with erase, these let the host unlock, lock, clear one word, clear all words, or fill all words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| if_en | input | 1 | 1: EEPROM interface active; 0: pins handed to general-purpose values |
| gpo_sclk | input | 1 | Value for the clock pin while the interface is disabled |
| gpo_data | input | 1 | Value for the data pin while the interface is disabled |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 6 | Word address |
| wdata_wr | input | 1 | Write-data register strobe |
| wdata_in | input | 16 | Word to be written |
| busy | output | 1 | Operation in progress |
| timeout | output | 1 | Sticky no-response flag |
| rdata | output | 16 | Last word read |
| mw_cs | output | 1 | Device chip select |
| mw_sk | output | 1 | Device serial clock |
| mw_do | output | 1 | Data toward the device |
| mw_do_oe | output | 1 | Drive enable for the shared data line |
| mw_di | input | 1 | Data from the device |

## Verification
The hardest situations to reach are the ones the device decides: a write that is still pending inside the EEPROM, and a device that never becomes ready. The bench models the device with its own memory, write-enable latch and ready delay. A hang switch in that model keeps the data line low through the whole poll, so the timeout path and the sticky flag can be reached. A second command is fired a few cycles into a pending write to check that the lock holds. The device model also counts the frames it receives, so a dropped or extra frame shows up directly.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int HDR_W  = 3 + ADDR_W;
    localparam int FRM_W  = HDR_W + DATA_W;
    localparam int CNT_W  = $clog2(FRM_W + 1);

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_EWEN  = 3'd3,
        OP_EWDS  = 3'd4,
        OP_ERAL  = 3'd5,
        OP_WRAL  = 3'd6,
        OP_RSVD  = 3'd7
    } host_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SEND, S_RECV, S_GAP, S_POLL
    } seq_st_e;

    typedef struct packed {
        host_op_e            op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } mw_req_t;

    // start bit, opcode and address of one frame (R4, R12)
    function automatic logic [HDR_W-1:0] mw_header(host_op_e op, logic [ADDR_W-1:0] a);
        logic [1:0]        opc;
        logic [ADDR_W-1:0] ad;
        ad = a;
        case (op)
            OP_READ:  opc = 2'b10;
            OP_WRITE: opc = 2'b01;
            OP_ERASE: opc = 2'b11;
            default: begin
                opc = 2'b00;
                case (op)
                    OP_EWEN: ad[ADDR_W-1 -: 2] = 2'b11;
                    OP_ERAL: ad[ADDR_W-1 -: 2] = 2'b10;
                    OP_WRAL: ad[ADDR_W-1 -: 2] = 2'b01;
                    default: ad[ADDR_W-1 -: 2] = 2'b00;
                endcase
            end
        endcase
        return {1'b1, opc, ad};
    endfunction

    function automatic logic carries_data(host_op_e op);
        return (op == OP_WRITE) || (op == OP_WRAL);
    endfunction

    function automatic logic needs_poll(host_op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_ERAL) || (op == OP_WRAL);
    endfunction

endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)              cnt <= '0;
        else if (cnt == W'(DIV - 1))  cnt <= '0;
        else                          cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == W'(DIV - 1));
endmodule

// File: rtl/mw_watch.sv
module mw_watch #(
    parameter int LIMIT = 3_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expire
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)                           cnt <= '0;
        else if (run && cnt != W'(LIMIT - 1))     cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/mw_seq.sv
module mw_seq
    import mw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mw_req_t           req,
    input  logic              tick,
    input  logic              abort,
    input  logic              di,
    output logic              cs,
    output logic              sk,
    output logic              dout,
    output logic              oe,
    output logic              run,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    seq_st_e            st;
    host_op_e           op_q;
    logic [FRM_W-1:0]   sh;
    logic [CNT_W-1:0]   cnt, last;
    logic [DATA_W-1:0]  rx;
    logic               cs_q, sk_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE;  op_q <= OP_READ;  sh <= '0;  cnt <= '0;  last <= '0;
            rx <= '0;  cs_q <= 1'b0;  sk_q <= 1'b0;  done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                st <= S_IDLE;  cs_q <= 1'b0;  sk_q <= 1'b0;
            end else begin
                case (st)
                    S_IDLE: if (start) begin
                        op_q <= req.op;
                        sh   <= {mw_header(req.op, req.addr), req.data};
                        last <= carries_data(req.op) ? CNT_W'(FRM_W - 1) : CNT_W'(HDR_W - 1);
                        cnt  <= '0;  cs_q <= 1'b1;  sk_q <= 1'b0;  st <= S_SEND;
                    end
                    S_SEND: if (tick) begin
                        if (!sk_q) sk_q <= 1'b1;
                        else begin
                            sk_q <= 1'b0;
                            if (cnt == last) begin
                                cnt <= '0;
                                if (op_q == OP_READ)      st <= S_RECV;
                                else if (needs_poll(op_q)) begin st <= S_GAP; cs_q <= 1'b0; end
                                else begin st <= S_IDLE; cs_q <= 1'b0; done_q <= 1'b1; end
                            end else begin
                                cnt <= cnt + 1'b1;
                                sh  <= {sh[FRM_W-2:0], 1'b0};
                            end
                        end
                    end
                    // dummy bit plus 16 data bits; the dummy falls off the top
                    S_RECV: if (tick) begin
                        if (!sk_q) begin
                            sk_q <= 1'b1;
                            rx   <= {rx[DATA_W-2:0], di};
                        end else begin
                            sk_q <= 1'b0;
                            if (cnt == CNT_W'(DATA_W)) begin
                                st <= S_IDLE;  cs_q <= 1'b0;  done_q <= 1'b1;
                            end else cnt <= cnt + 1'b1;
                        end
                    end
                    S_GAP: if (tick) begin
                        cs_q <= 1'b1;  st <= S_POLL;
                    end
                    S_POLL: if (tick) begin
                        if (sk_q)    sk_q <= 1'b0;
                        else if (di) begin st <= S_IDLE; cs_q <= 1'b0; done_q <= 1'b1; end
                        else         sk_q <= 1'b1;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    assign cs      = cs_q;
    assign sk      = sk_q;
    assign oe      = (st == S_SEND);
    assign dout    = sh[FRM_W-1] & (st == S_SEND);
    assign run     = (st != S_IDLE);
    assign done    = done_q;
    assign rx_word = rx;
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int CLK_DIV   = 50,
    parameter int TO_CYCLES = 3_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              if_en,
    input  logic              gpo_sclk,
    input  logic              gpo_data,
    input  logic              cmd_wr,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wdata_wr,
    input  logic [DATA_W-1:0] wdata_in,
    output logic              busy,
    output logic              timeout,
    output logic [DATA_W-1:0] rdata,
    output logic              mw_cs,
    output logic              mw_sk,
    output logic              mw_do,
    output logic              mw_do_oe,
    input  logic              mw_di
);
    logic              busy_q, to_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    host_op_e          cur_op;
    mw_req_t           req;
    logic              accept, tick, expire;
    logic              s_cs, s_sk, s_do, s_oe, s_run, s_done;
    logic [DATA_W-1:0] s_rx;

    assign accept = cmd_wr && if_en && !busy_q;
    assign req    = '{op: host_op_e'(cmd_op), addr: cmd_addr, data: wdata_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;  to_q <= 1'b0;  wdata_q <= '0;  rdata_q <= '0;  cur_op <= OP_READ;
        end else begin
            if (wdata_wr) wdata_q <= wdata_in;
            if (accept) begin
                busy_q <= 1'b1;  to_q <= 1'b0;  cur_op <= host_op_e'(cmd_op);
            end else if (s_done) begin
                busy_q <= 1'b0;
                if (cur_op == OP_READ) rdata_q <= s_rx;
            end else if (expire) begin
                busy_q <= 1'b0;  to_q <= 1'b1;
            end
        end
    end

    mw_tick #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst(rst), .run(s_run), .tick(tick)
    );

    mw_watch #(.LIMIT(TO_CYCLES)) u_watch (
        .clk(clk), .rst(rst), .clr(accept), .run(busy_q), .expire(expire)
    );

    mw_seq u_seq (
        .clk(clk), .rst(rst), .start(accept), .req(req), .tick(tick),
        .abort(expire), .di(mw_di),
        .cs(s_cs), .sk(s_sk), .dout(s_do), .oe(s_oe), .run(s_run),
        .done(s_done), .rx_word(s_rx)
    );

    assign busy     = busy_q;
    assign timeout  = to_q;
    assign rdata    = rdata_q;
    assign mw_cs    = if_en ? s_cs : 1'b0;
    assign mw_sk    = if_en ? s_sk : gpo_sclk;
    assign mw_do    = if_en ? s_do : gpo_data;
    assign mw_do_oe = if_en ? s_oe : 1'b1;
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       if_en,
    input logic       cmd_wr,
    input logic       busy,
    input logic       timeout,
    input logic       mw_cs,
    input logic       mw_sk,
    input logic       mw_do,
    input logic [2:0] cur_op
);
    p_busy_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_wr && if_en));

    p_busy_lock_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> $stable(cur_op));

    p_do_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (if_en && mw_cs && $rose(mw_sk)) |-> $stable(mw_do));

    p_abort_r8: assert property (@(posedge clk) disable iff (rst)
        (if_en && $rose(timeout)) |-> (!busy && !mw_cs));

    p_to_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && if_en && !busy) |=> (busy && !timeout));

    p_no_start_r10: assert property (@(posedge clk) disable iff (rst)
        (!if_en && !busy) |=> !busy);

    p_sk_low_r11: assert property (@(posedge clk) disable iff (rst)
        (if_en && !mw_cs) |-> !mw_sk);
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .if_en(if_en), .cmd_wr(cmd_wr), .busy(busy),
    .timeout(timeout), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_do(mw_do), .cur_op(cur_op)
);

// File: tb/mw_eeprom_ctrl_tb.sv
module mw_eeprom_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 2;
    localparam int TO  = 400;
    localparam int DEV_DLY = 30;
    localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_ER = 3'd2, C_EWEN = 3'd3,
                           C_EWDS = 3'd4, C_ERAL = 3'd5, C_WRAL = 3'd6;

    logic clk = 1'b0, rst = 1'b1;
    logic if_en = 1'b1, gpo_sclk = 1'b0, gpo_data = 1'b0;
    logic cmd_wr = 1'b0, wdata_wr = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [5:0] cmd_addr = '0;
    logic [15:0] wdata_in = '0;
    logic busy, timeout, mw_cs, mw_sk, mw_do, mw_do_oe;
    logic mw_di = 1'b0;
    logic [15:0] rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_ctrl #(.CLK_DIV(DIV), .TO_CYCLES(TO)) u_dut (
        .clk(clk), .rst(rst), .if_en(if_en), .gpo_sclk(gpo_sclk), .gpo_data(gpo_data),
        .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .wdata_wr(wdata_wr), .wdata_in(wdata_in),
        .busy(busy), .timeout(timeout), .rdata(rdata),
        .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_do(mw_do), .mw_do_oe(mw_do_oe), .mw_di(mw_di)
    );

    int n_chk = 0, n_bad = 0;
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural EEPROM device ----------------
    typedef enum {D_IDLE, D_HDR, D_DATA, D_READ, D_DONE, D_POLL} dmode_e;
    logic [15:0] dmem [64];
    logic [15:0] exp_mem [64];
    logic dev_we = 1'b0, dev_hang = 1'b0;
    int dev_rdy = 0, frames = 0, nb = 0, pend = 0;
    dmode_e dm = D_IDLE;
    logic cs_p = 1'b0, sk_p = 1'b0;
    logic [7:0] hdr;
    logic [15:0] din, rword;
    logic [5:0] pa;

    always @(negedge clk) begin
        if (dev_rdy > 0) dev_rdy--;
        if (!mw_cs) begin
            if (cs_p) begin
                if (dm == D_POLL) dm = D_IDLE;
                else begin
                    dm = D_IDLE;
                    if (pend >= 1 && pend <= 4) begin
                        if (dev_we) begin
                            case (pend)
                                1: dmem[pa] = din;
                                2: dmem[pa] = 16'hFFFF;
                                3: for (int i = 0; i < 64; i++) dmem[i] = 16'hFFFF;
                                default: for (int i = 0; i < 64; i++) dmem[i] = din;
                            endcase
                        end
                        dm = D_POLL;
                        dev_rdy = dev_we ? DEV_DLY : 0;
                    end else if (pend == 5) dev_we = 1'b1;
                    else if (pend == 6) dev_we = 1'b0;
                    pend = 0;
                end
            end
            if (dm != D_POLL) mw_di = 1'b0;
        end else if (mw_sk && !sk_p) begin
            case (dm)
                D_IDLE: if (mw_do) begin dm = D_HDR; nb = 0; end
                D_HDR: begin
                    hdr = {hdr[6:0], mw_do};
                    nb++;
                    if (nb == 8) begin
                        frames++;
                        pa = hdr[5:0];
                        dm = D_DONE;
                        case (hdr[7:6])
                            2'b10: begin dm = D_READ; rword = dmem[pa]; mw_di = 1'b0; end
                            2'b01: begin pend = 1; dm = D_DATA; nb = 0; end
                            2'b11: pend = 2;
                            default: case (hdr[5:4])
                                2'b11: pend = 5;
                                2'b00: pend = 6;
                                2'b10: pend = 3;
                                default: begin pend = 4; dm = D_DATA; nb = 0; end
                            endcase
                        endcase
                    end
                end
                D_DATA: begin
                    din = {din[14:0], mw_do};
                    nb++;
                    if (nb == 16) dm = D_DONE;
                end
                D_READ: begin mw_di = rword[15]; rword = rword << 1; end
                default: ;
            endcase
        end
        cs_p = mw_cs;
        sk_p = mw_sk;
        if (dm == D_POLL && mw_cs) mw_di = (dev_rdy == 0) && !dev_hang;
    end

    // ---------------- per-clock pin reference ----------------
    int cyc = 0, last_rise = -1, bcnt = 0;
    logic sk_m = 1'b0, do_m = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!if_en)
                chk("R10 pins follow gpo", {29'd0, mw_cs, mw_sk, mw_do}, {29'd0, 1'b0, gpo_sclk, gpo_data});
            else if (!mw_cs)
                chk("R11 clock low while deselected", {31'd0, mw_sk}, 32'd0);
            if (if_en && mw_cs && mw_sk && !sk_m) begin
                chk("R4 data held over rising edge", {31'd0, mw_do}, {31'd0, do_m});
                if (last_rise >= 0) chk("R11 clock period", cyc - last_rise, 2*DIV);
                last_rise = cyc;
            end
            if (!mw_cs) last_rise = -1;
            bcnt = busy ? bcnt + 1 : 0;
            if (bcnt == TO + 2) chk("R8 busy exceeds limit", bcnt, TO);
        end
        sk_m = mw_sk;
        do_m = mw_do;
    end

    // ---------------- host tasks ----------------
    task automatic load_wdata(logic [15:0] d);
        @(negedge clk); wdata_in = d; wdata_wr = 1'b1;
        @(negedge clk); wdata_wr = 1'b0;
    endtask

    task automatic issue(logic [2:0] op, logic [5:0] a);
        @(negedge clk); cmd_op = op; cmd_addr = a; cmd_wr = 1'b1;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic run_cmd(logic [2:0] op, logic [5:0] a, output int cycles);
        issue(op, a);
        cycles = 1;
        chk("R2 busy after accept", {31'd0, busy}, 32'd1);
        chk("R9 timeout cleared on accept", {31'd0, timeout}, 32'd0);
        while (busy && cycles < TO + 50) begin
            @(negedge clk); cycles++;
        end
    endtask

    task automatic read_chk(logic [5:0] a, string req);
        int c;
        run_cmd(C_RD, a, c);
        chk(req, {16'd0, rdata}, {16'd0, exp_mem[a]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R2 actual=busy_hang expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c, f0;
        for (int i = 0; i < 64; i++) begin
            dmem[i] = 16'hC000 ^ (16'(i) * 16'h0111);
            exp_mem[i] = dmem[i];
        end
        repeat (5) @(negedge clk);
        chk("R1 busy in reset", {31'd0, busy}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 timeout", {31'd0, timeout}, 32'd0);
        chk("R1 cs/sk", {30'd0, mw_cs, mw_sk}, 32'd0);
        chk("R1 rdata", {16'd0, rdata}, 32'd0);

        // write before unlock has no effect (R12)
        load_wdata(16'h1234);
        run_cmd(C_WR, 6'd3, c);
        read_chk(6'd3, "R12 write while locked");

        // unlock, write, read back (R5 R6 R7)
        run_cmd(C_EWEN, 6'd0, c);
        load_wdata(16'hA5C3);
        run_cmd(C_WR, 6'd3, c);
        exp_mem[3] = 16'hA5C3;
        chk("R7 write waits for ready", {31'd0, c > DEV_DLY}, 32'd1);
        chk("R8 no timeout on normal write", {31'd0, timeout}, 32'd0);
        read_chk(6'd3, "R5 R6 write then read");
        read_chk(6'd0, "R6 read address 0");
        read_chk(6'd63, "R6 read address 63");

        // single erase
        run_cmd(C_ER, 6'd3, c);
        exp_mem[3] = 16'hFFFF;
        read_chk(6'd3, "R12 erase one word");

        // command while busy is ignored (R3)
        load_wdata(16'h0F0F);
        f0 = frames;
        issue(C_WR, 6'd10);
        repeat (3) @(negedge clk);
        issue(C_WR, 6'd11);
        while (busy) @(negedge clk);
        exp_mem[10] = 16'h0F0F;
        chk("R3 one frame only", frames - f0, 1);
        read_chk(6'd10, "R3 first write kept");
        read_chk(6'd11, "R3 second write dropped");

        // write-all and erase-all (R12)
        load_wdata(16'h5A5A);
        run_cmd(C_WRAL, 6'd0, c);
        for (int i = 0; i < 64; i++) exp_mem[i] = 16'h5A5A;
        read_chk(6'd0, "R12 write-all low");
        read_chk(6'd37, "R12 write-all mid");
        read_chk(6'd63, "R12 write-all high");
        run_cmd(C_ERAL, 6'd0, c);
        for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
        read_chk(6'd20, "R12 erase-all");

        // lock again
        run_cmd(C_EWDS, 6'd0, c);
        load_wdata(16'h1111);
        run_cmd(C_WR, 6'd5, c);
        read_chk(6'd5, "R12 write after disable");

        // device never ready (R8 R9)
        run_cmd(C_EWEN, 6'd0, c);
        dev_hang = 1'b1;
        load_wdata(16'h2222);
        run_cmd(C_WR, 6'd7, c);
        exp_mem[7] = 16'h2222;
        chk("R8 timeout set", {31'd0, timeout}, 32'd1);
        chk("R8 abort cycle", c, TO + 1);
        chk("R8 cs dropped", {31'd0, mw_cs}, 32'd0);
        repeat (20) @(negedge clk);
        chk("R8 timeout sticky", {31'd0, timeout}, 32'd1);
        dev_hang = 1'b0;
        read_chk(6'd7, "R9 read after timeout");
        chk("R9 timeout stays clear", {31'd0, timeout}, 32'd0);

        // interface disabled (R10)
        if_en = 1'b0;
        f0 = frames;
        gpo_sclk = 1'b1; gpo_data = 1'b0;
        issue(C_WR, 6'd1);
        chk("R10 no busy when disabled", {31'd0, busy}, 32'd0);
        gpo_sclk = 1'b0; gpo_data = 1'b1;
        repeat (4) @(negedge clk);
        gpo_sclk = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 no frame when disabled", frames - f0, 0);
        gpo_sclk = 1'b0; gpo_data = 1'b0;
        @(negedge clk);
        if_en = 1'b1;
        read_chk(6'd1, "R10 memory untouched");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule